// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands with one add step per bit of the multiplier. Each operand has its own load strobe into a holding register: the multiplicand is widened with zeros to double width, and the multiplier sits in a single-width register. A start pulse in the idle state clears the accumulator and begins the run.

In each work cycle a pass-or-zero selector offers the accumulator either the current multiplicand or zero, according to the multiplier's lowest bit. In the same cycle the multiplicand moves one place left and the multiplier moves one place right. A small counter steps through the work states and returns to idle on its own.

The product is read from the accumulator. It is final, and stays unchanged, while `done` is high.

Top module: `shiftadd_mult`

## Requirements
- R1: While reset is held, and right after it, `done` is 1 and `product` is 0.
- R2: In idle with `start` low, `done` stays 1 and `product` keeps its value cycle after cycle.
- R3: `start` sampled high in idle zeroes the accumulator on that clock edge and drops `done` on that edge.
- R4: After the edge that accepts `start`, the controller makes exactly 8 work steps (work states are numbered 1000 to 1111 in binary, idle is 0000). `done` is low after each of the edges 0 to 7 and rises on the 8th edge after the start edge.
- R5: When `done` returns, `product` equals `a*b` for the unsigned 8-bit operands loaded.
- R6: After the k-th work edge (k = 1 to 8), `product` equals `a * (b mod 2^k)`. A multiplier bit of 0 adds zero, and a bit of 1 adds the multiplicand shifted left by the bit's index.
- R7: Operand load strobes are ignored while `done` is low. The result of the running multiply is unaffected.
- R8: Operand loads presented in the same cycle as an accepted `start` take effect and are used by that run.
- R9: `start` while `done` is low is ignored. Neither the step count nor the result changes.
- R10: The product stays stable in idle until the next accepted `start`.
- R11: A run consumes its operands: the multiplier register is emptied. A second `start` with no new load therefore yields a product of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| start | input | 1 | Begin a multiply when idle |
| mcand_in | input | 8 | Multiplicand operand |
| mcand_ld | input | 1 | Load strobe for the multiplicand (idle only) |
| mplier_in | input | 8 | Multiplier operand |
| mplier_ld | input | 1 | Load strobe for the multiplier (idle only) |
| product | output | 16 | Accumulator contents |
| done | output | 1 | High in idle; the product is final |

## Verification
Two things can happen in the same cycle: the accumulator clear caused by `start`, and the operand loads. Every sweep run raises both load strobes together with `start`, so the bench verifies that the freshly loaded values, and not stale ones, drive all eight partial sums. Those sums are checked after every work edge. A second collision is provoked by pulsing the loads and `start` together in mid-run. There the judgement is that the final product and the step on which `done` returns are those of the undisturbed operands.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef struct packed {
    logic clr;    // zero the accumulator
    logic step;   // add selected term, shift both operands
    logic ld_en;  // operand loads allowed
  } mul_ctl_t;
endpackage

// File: rtl/mul_pass_zero.sv
module mul_pass_zero #(
  parameter int W = 16
) (
  input  logic         sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[i] & sel;
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  output mul_ctl_t ctl,
  output logic     idle
);
  localparam int SW = $clog2(OPW) + 1;
  localparam logic [SW-1:0] ST_IDLE  = '0;
  localparam logic [SW-1:0] ST_FIRST = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] ST_LAST  = '1;

  logic [SW-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (st_q == ST_IDLE) begin
      if (start) st_d = ST_FIRST;
    end else if (st_q == ST_LAST) begin
      st_d = ST_IDLE;
    end else begin
      st_d = st_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign idle      = (st_q == ST_IDLE);
  assign ctl.clr   = idle & start;
  assign ctl.step  = st_q[SW-1];
  assign ctl.ld_en = idle;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start) |=> st_q == ST_IDLE);
  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[SW-1] && st_q != ST_LAST) |=> st_q == $past(st_q) + 1'b1);
  assert_last_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LAST) |=> st_q == ST_IDLE);
  assert_start_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start) |=> st_q == ST_FIRST);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  mul_ctl_t       ctl,
  input  logic [OPW-1:0] mcand_in,
  input  logic           mcand_ld,
  input  logic [OPW-1:0] mplier_in,
  input  logic           mplier_ld,
  output logic [2*OPW-1:0] acc_o
);
  localparam int PW = 2 * OPW;

  logic [PW-1:0]  mcand_q, mcand_d, acc_q, acc_d, addend;
  logic [OPW-1:0] mplier_q, mplier_d;
  logic           mcand_en, mplier_en, acc_en;

  mul_pass_zero #(.W(PW)) u_sel (
    .sel  (mplier_q[0]),
    .din  (mcand_q),
    .dout (addend)
  );

  always_comb begin
    mcand_en  = (ctl.ld_en & mcand_ld) | ctl.step;
    mplier_en = (ctl.ld_en & mplier_ld) | ctl.step;
    acc_en    = ctl.clr | ctl.step;
    mcand_d   = ctl.step ? (mcand_q << 1) : {{OPW{1'b0}}, mcand_in};
    mplier_d  = ctl.step ? (mplier_q >> 1) : mplier_in;
    acc_d     = ctl.clr ? '0 : acc_q + addend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else begin
      if (mcand_en)  mcand_q  <= mcand_d;
      if (mplier_en) mplier_q <= mplier_d;
      if (acc_en)    acc_q    <= acc_d;
    end
  end

  assign acc_o = acc_q;

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr |=> acc_q == '0);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.clr && !ctl.step) |=> $stable(acc_q));
  assert_busy_noload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.step |=> mplier_q == ($past(mplier_q) >> 1));
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int OPW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OPW-1:0]   mcand_in,
  input  logic             mcand_ld,
  input  logic [OPW-1:0]   mplier_in,
  input  logic             mplier_ld,
  output logic [2*OPW-1:0] product,
  output logic             done
);
  import mul_pkg::*;

  logic [1:0] rsync_q;
  logic       rst_q_n;
  mul_ctl_t   ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  mul_ctrl #(.OPW(OPW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_q_n),
    .start (start),
    .ctl   (ctl),
    .idle  (done)
  );

  mul_datapath #(.OPW(OPW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .ctl       (ctl),
    .mcand_in  (mcand_in),
    .mcand_ld  (mcand_ld),
    .mplier_in (mplier_in),
    .mplier_ld (mplier_ld),
    .acc_o     (product)
  );
endmodule

// File: tb/sim_shiftadd_mult.sv
module sim_shiftadd_mult;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  mcand_in = '0, mplier_in = '0;
  logic        mcand_ld = 1'b0, mplier_ld = 1'b0;
  logic [15:0] product;
  logic        done;
  int          n_chk = 0, n_err = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  shiftadd_mult u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand_in(mcand_in), .mcand_ld(mcand_ld),
    .mplier_in(mplier_in), .mplier_ld(mplier_ld),
    .product(product), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // start with loads in the same cycle (R8), then check every step (R3 R4 R6 R5)
  task automatic run(input int a, input int b);
    @(negedge clk);
    mcand_in = a[7:0]; mplier_in = b[7:0];
    mcand_ld = 1'b1; mplier_ld = 1'b1; start = 1'b1;
    @(negedge clk);
    mcand_ld = 1'b0; mplier_ld = 1'b0; start = 1'b0;
    chk("R3 acc cleared", product, 0);
    chk("R3 done low", done, 0);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R6 partial sum R8", product, a * (b % (1 << k)));
      chk("R4 done timing", done, (k == 8) ? 1 : 0);
    end
    chk("R5 product", product, a * b);
  endtask

  initial begin
    #2000000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done in reset", done, 1);
    chk("R1 product in reset", product, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", done, 1);
    chk("R1 product after reset", product, 0);

    run(4, 3);
    run(3, 4);
    // R2 / R10: idle with no start keeps result
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R2 idle done", done, 1);
      chk("R10 product stable", product, 12);
    end

    // R7 / R9: loads and start during busy are ignored
    @(negedge clk);
    mcand_in = 8'd200; mplier_in = 8'd77;
    mcand_ld = 1'b1; mplier_ld = 1'b1; start = 1'b1;
    @(negedge clk);
    mcand_ld = 1'b0; mplier_ld = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    mcand_in = 8'd9; mplier_in = 8'd255;
    mcand_ld = 1'b1; mplier_ld = 1'b1; start = 1'b1;
    @(negedge clk);
    mcand_ld = 1'b0; mplier_ld = 1'b0; start = 1'b0;
    chk("R9 still busy", done, 0);
    repeat (3) @(negedge clk);
    chk("R9 done at step 8", done, 0);
    @(negedge clk);
    chk("R9 done rises on 8th", done, 1);
    chk("R7 result unaffected", product, 200 * 77);
    @(negedge clk);
    chk("R9 no extra run", done, 1);

    // R11: restart without reload gives zero
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk("R11 done", done, 1);
    chk("R11 consumed operands", product, 0);

    // load in idle, start a later cycle (R8 alternative path)
    mcand_in = 8'd13; mplier_in = 8'd11; mcand_ld = 1'b1; mplier_ld = 1'b1;
    @(negedge clk);
    mcand_ld = 1'b0; mplier_ld = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    chk("R5 preloaded 13x11", product, 143);

    // sweeps
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 17) run(a, b);
      run(a, 1); run(a, 128); run(a, 254); run(a, 255);
    end
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run(int'(lfsr[15:8]), int'(lfsr[7:0]));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule